// File: doc/BRIEF.md
# Debug Wire Protocol Mode Selector

This block watches the shared debug data line (the pin that is TMS in JTAG use and SWDIO in serial-wire use). It samples that line on every rising edge of the shared debug clock and decides which of the two debug protocols owns the port. A protocol switch takes three steps. First comes a line reset, a long run of high bits. Then a 16-bit select code follows at once, sent least significant bit first. Last comes a second line reset. Only when that second run completes does the mode output move, and a one-cycle strobe marks the change.

The mode after reset is JTAG. Four select codes are recognised. Two of them pick the serial-wire protocol and two pick JTAG; in each pair one code is current and one is an older alternate. The line-reset output tells the protocol engines downstream to return to their own reset states. It is high for as long as the line has been high for the threshold number of consecutive samples.

Top module: `swj_mode_detect`

## Requirements
- R1: While reset is applied and directly after it, mode_swd_o is 0 (JTAG), mode_chg_o is 0 and line_rst_o is 0.
- R2: line_rst_o is 1 after the clock edge at which the line has been sampled high on RUN_LEN (default 50) consecutive edges. It is 0 after RUN_LEN-1 such edges, and it returns to 0 after any edge that samples the line low.
- R3: The run count saturates, so line_rst_o stays 1 for a high run of any length.
- R4: The 16-bit value 16'hE79E (low byte first, each byte least significant bit first) selects the serial-wire mode (mode_swd_o = 1).
- R5: The 16-bit value 16'hE73C, sent in the same bit order, selects JTAG (mode_swd_o = 0).
- R6: The older alternates are also accepted: 16'hEDB6 selects serial-wire and 16'hDEAE selects JTAG.
- R7: A code counts only if its first bit, always a 0, is the first low sample after a completed line reset. A code that follows a shorter high run is ignored.
- R8: After a matching code, the mode moves at the edge that completes RUN_LEN consecutive high samples counted from the bit after the code, and not before. Low samples in between restart that count but do not cancel the pending selection.
- R9: A 16-bit window that matches none of the codes leaves the mode unchanged, and the block waits for the next line reset.
- R10: A code that selects the mode already active changes nothing and does not pulse mode_chg_o. line_rst_o still rises when the following run completes.
- R11: mode_chg_o is high for exactly the one cycle after the edge at which mode_swd_o toggles, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared debug clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Shared debug data line, already synchronised |
| mode_swd_o | output | 1 | 1 = serial-wire protocol selected, 0 = JTAG |
| mode_chg_o | output | 1 | One-cycle strobe when mode_swd_o toggles |
| line_rst_o | output | 1 | High while a line reset is in effect |

## Verification
A wrong run count shows at once on line_rst_o, one edge early or late at the RUN_LEN boundary. It also shows as a select code that is taken or ignored wrongly. A fault in the code shifter or the decoder only appears RUN_LEN cycles after the code ends, when mode_swd_o moves or fails to move. A lost pending selection shows up in the same late way, so each code is followed by a full run and the mode is checked at the exact completing edge. Random sequences mix valid codes, corrupted windows and runs near the boundary, and a bit-level reference model compares all three outputs after every edge.

// File: rtl/swj_pkg.sv
package swj_pkg;

  localparam int SEL_W    = 16;
  localparam int NUM_SEL  = 4;

  // Selection codes as seen in the shift window (first received bit = bit 0).
  localparam logic [SEL_W-1:0] SEL_CODES [NUM_SEL] = '{
    16'hE79E,   // serial-wire, current
    16'hEDB6,   // serial-wire, older alternate
    16'hE73C,   // JTAG, current
    16'hDEAE    // JTAG, older alternate
  };
  localparam logic [NUM_SEL-1:0] SEL_TO_SWD = 4'b0011;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ARMED = 2'd2
  } swj_state_e;

endpackage

// File: rtl/swj_run_counter.sv
module swj_run_counter #(
  parameter int RUN_LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic sat_o,
  output logic sat_nxt_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CMAX = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i || !line_i)  cnt_d = '0;
    else if (cnt_q == CMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign sat_o     = (cnt_q == CMAX);
  assign sat_nxt_o = (cnt_d == CMAX);

endmodule

// File: rtl/swj_code_shift.sv
module swj_code_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] window_o,
  output logic         last_o
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] ILAST = IW'(W - 1);

  logic [W-1:0]  sr_q, sr_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          shift;

  assign shift    = start_i || en_i;
  assign window_o = {bit_i, sr_q[W-1:1]};
  assign last_o   = en_i && (idx_q == ILAST);

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    if (shift) sr_d = window_o;
    if (start_i)   idx_d = IW'(1);
    else if (en_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/swj_code_decode.sv
module swj_code_decode
  import swj_pkg::*;
(
  input  logic [SEL_W-1:0] window_i,
  output logic             hit_o,
  output logic             to_swd_o
);
  logic [NUM_SEL-1:0] hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_cmp
    assign hit[g] = (window_i == SEL_CODES[g]);
  end

  assign hit_o    = |hit;
  assign to_swd_o = |(hit & SEL_TO_SWD);

endmodule

// File: rtl/swj_mode_detect.sv
module swj_mode_detect
  import swj_pkg::*;
#(
  parameter int RUN_LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic mode_swd_o,
  output logic mode_chg_o,
  output logic line_rst_o
);
  swj_state_e      st_q, st_d;
  logic            pend_q, pend_d;
  logic            mode_q, mode_d;
  logic            chg_q, chg_d;
  logic            sat, sat_nxt;
  logic            start, shift_en, last, hit, to_swd, match, apply;
  logic [SEL_W-1:0] window;

  swj_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_i),
    .clr_i     (match),
    .sat_o     (sat),
    .sat_nxt_o (sat_nxt)
  );

  swj_code_shift #(.W(SEL_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .en_i     (shift_en),
    .bit_i    (line_i),
    .window_o (window),
    .last_o   (last)
  );

  swj_code_decode u_dec (
    .window_i (window),
    .hit_o    (hit),
    .to_swd_o (to_swd)
  );

  assign start    = (st_q == ST_HUNT) && sat && !line_i;
  assign shift_en = (st_q == ST_SHIFT);
  assign match    = last && hit;
  assign apply    = (st_q == ST_ARMED) && sat_nxt;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_HUNT:  if (start) st_d = ST_SHIFT;
      ST_SHIFT: if (last) begin
                  st_d = hit ? ST_ARMED : ST_HUNT;
                  if (hit) pend_d = to_swd;
                end
      ST_ARMED: if (apply) st_d = ST_HUNT;
      default:  st_d = ST_HUNT;
    endcase
    mode_d = apply ? pend_q : mode_q;
    chg_d  = apply && (pend_q != mode_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      pend_q <= 1'b0;
      mode_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
      chg_q  <= chg_d;
    end
  end

  assign mode_swd_o = mode_q;
  assign mode_chg_o = chg_q;
  assign line_rst_o = sat;

endmodule

// File: rtl/swj_mode_detect_chk.sv
module swj_mode_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic mode_swd_o,
  input logic mode_chg_o,
  input logic line_rst_o
);
  p_lrst_needs_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_rst_o |-> $past(line_i));

  p_lrst_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_rst_o && line_i) |=> line_rst_o);

  p_mode_on_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_swd_o != $past(mode_swd_o)) |-> line_rst_o);

  p_chg_toggles_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> (mode_swd_o != $past(mode_swd_o)));

  p_chg_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> !mode_chg_o);

  p_toggle_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_swd_o != $past(mode_swd_o)) |-> mode_chg_o);

endmodule

bind swj_mode_detect swj_mode_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_i     (line_i),
  .mode_swd_o (mode_swd_o),
  .mode_chg_o (mode_chg_o),
  .line_rst_o (line_rst_o)
);

// File: tb/swj_mode_detect_bench.sv
module swj_mode_detect_bench;
  localparam int RUN = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line = 1'b0;
  logic mode_swd, mode_chg, line_rst;

  swj_mode_detect #(.RUN_LEN(RUN)) u_swj_mode_detect (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line),
    .mode_swd_o(mode_swd), .mode_chg_o(mode_chg), .line_rst_o(line_rst)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, chg_seen = 0;
  bit done = 0;

  // Reference model, written from the requirements
  int m_cnt = 0, m_st = 0, m_idx = 0;
  logic [15:0] m_sr = '0;
  logic m_mode = 0, m_pend = 0, m_chg = 0;

  function automatic int code_kind(logic [15:0] c);
    if (c == 16'hE79E || c == 16'hEDB6) return 1;
    if (c == 16'hE73C || c == 16'hDEAE) return 0;
    return -1;
  endfunction

  task automatic model_step(logic b);
    bit clr = 0;
    logic [15:0] win;
    int nx;
    m_chg = 0;
    if (m_st == 1) begin
      win = {b, m_sr[15:1]};
      m_sr = win;
      if (m_idx == 15) begin
        if (code_kind(win) >= 0) begin
          m_pend = (code_kind(win) == 1); m_st = 2; clr = 1;
        end else m_st = 0;
      end else m_idx++;
    end else if (m_st == 0 && m_cnt == RUN && !b) begin
      m_st = 1; m_sr = {b, m_sr[15:1]}; m_idx = 1;
    end
    nx = clr ? 0 : (b ? ((m_cnt == RUN) ? RUN : m_cnt + 1) : 0);
    if (m_st == 2 && nx == RUN) begin
      m_chg = (m_pend != m_mode); m_mode = m_pend; m_st = 0;
    end
    m_cnt = nx;
  endtask

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {mode,chg,lrst} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic push_bit(logic b);
    line = b;
    @(posedge clk);
    model_step(b);
    @(negedge clk);
    if (mode_chg) chg_seen++;
    check("R11 per-cycle model", {mode_swd, mode_chg, line_rst},
          {m_mode, m_chg, (m_cnt == RUN) ? 1'b1 : 1'b0});
  endtask

  task automatic push_run(int n);
    for (int i = 0; i < n; i++) push_bit(1'b1);
  endtask

  task automatic push_code(logic [15:0] c);
    for (int i = 0; i < 16; i++) push_bit(c[i]);
  endtask

  task automatic expect_mode(string req, logic exp);
    n_chk++;
    if (mode_swd !== exp) begin
      n_bad++;
      $display("FAIL %s: mode_swd actual %b expected %b", req, mode_swd, exp);
    end
  endtask

  task automatic expect_lrst(string req, logic exp);
    n_chk++;
    if (line_rst !== exp) begin
      n_bad++;
      $display("FAIL %s: line_rst actual %b expected %b", req, line_rst, exp);
    end
  endtask

  task automatic expect_chg(string req, logic exp);
    n_chk++;
    if (mode_chg !== exp) begin
      n_bad++;
      $display("FAIL %s: mode_chg actual %b expected %b", req, mode_chg, exp);
    end
  endtask

  initial begin
    logic [15:0] codes [4] = '{16'hE79E, 16'hEDB6, 16'hE73C, 16'hDEAE};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset", {mode_swd, mode_chg, line_rst}, 3'b000);
    rst_ni = 1'b1;
    check("R1 after release", {mode_swd, mode_chg, line_rst}, 3'b000);

    push_run(RUN - 1);   expect_lrst("R2 one short", 1'b0);
    push_bit(1'b1);      expect_lrst("R2 threshold", 1'b1);
    push_run(200);       expect_lrst("R3 saturated run", 1'b1);

    push_code(16'hE79E); push_run(RUN - 1);
    expect_mode("R8 before trailing run done", 1'b0);
    push_bit(1'b1);
    expect_mode("R4 select serial-wire", 1'b1);
    expect_chg("R11 strobe on toggle", 1'b1);
    push_bit(1'b1);
    expect_chg("R11 strobe one cycle", 1'b0);

    push_code(16'hE73C); push_run(RUN);
    expect_mode("R5 select JTAG", 1'b0);

    chg_seen = 0;
    push_code(16'hE73C); push_run(RUN);
    expect_mode("R10 same mode", 1'b0);
    n_chk++; if (chg_seen != 0) begin n_bad++;
      $display("FAIL R10: strobes actual %0d expected 0", chg_seen); end
    expect_lrst("R10 reset still indicated", 1'b1);

    push_code(16'hEDB6); push_run(RUN);
    expect_mode("R6 alternate serial-wire", 1'b1);
    push_code(16'hDEAE); push_run(RUN);
    expect_mode("R6 alternate JTAG", 1'b0);

    push_bit(1'b0); push_run(RUN - 1);
    push_code(16'hE79E); push_run(RUN + 10);
    expect_mode("R7 short leading run", 1'b0);

    push_code(16'hE79C); push_run(RUN + 10);
    expect_mode("R9 mismatched window", 1'b0);

    push_code(16'hE79E); push_run(20); push_bit(1'b0); push_run(RUN - 1);
    expect_mode("R8 restarted count", 1'b0);
    push_bit(1'b1);
    expect_mode("R8 pending kept", 1'b1);

    for (int s = 0; s < 300; s++) begin
      int k = $urandom_range(0, 5);
      case (k)
        0, 1: push_run($urandom_range(RUN - 5, RUN + 10));
        2:    push_code(codes[$urandom_range(0, 3)]);
        3:    push_code(16'($urandom));
        4:    for (int j = 0; j < $urandom_range(1, 8); j++) push_bit(1'($urandom));
        default: push_bit(1'b0);
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule